// File: doc/BRIEF.md
# Circuit-Switched Path Setup Gateway

This block is the electronic controller at one node's entry point into a circuit-switched optical network. The node hands it a message descriptor made of a destination id and a byte length. For the optical route the gateway first sends a setup control packet toward the destination. It then waits for a matching acknowledgement. Once that arrives it streams the payload as fixed-width beats and finishes with a breakdown control packet that frees the path.

With selective mode switched on, a short message skips path setup entirely. Its beats go out at once over the electronic control network. A negative acknowledgement means the path is blocked; the gateway then waits a programmable number of cycles and retries the setup. The node is held off until the current message is finished. The payload itself is fetched from the node through a beat index and data pair.

Top module: `path_gateway`

## Requirements
- R1: After reset, and after a reset applied in the middle of a message, req_ready is 1, cp_out_valid is 0 and dout_valid is 0.
- R2: A request is taken in a cycle with req_valid and req_ready both 1. req_ready then stays 0 until the message is complete, and it is 1 again in the cycle after the final beat (electronic) or after the breakdown packet (optical).
- R3: For an optical message, cp_out_valid is 1 for exactly the one cycle after acceptance. In that cycle cp_out_type is 2'b00 (setup), cp_out_src is NODE_ID and cp_out_dst is the requested destination.
- R4: No optical beat is sent before an acknowledgement arrives in the waiting phase. An acknowledgement has cp_in_type 2'b01, cp_in_src equal to the outstanding destination and cp_in_dst equal to NODE_ID. The first beat appears in the cycle after it.
- R5: An acknowledgement whose source differs from the outstanding destination, or whose destination is not NODE_ID, has no effect; so has any acknowledgement while idle.
- R6: A message has ceil(length/BEAT_BYTES) beats, and a length of 0 counts as one beat. The beats come out on consecutive cycles with beat_idx running 0, 1, ... and dout_data equal to beat_data. dout_last is 1 on the final beat only. dout_optical is 1 on optical beats and 0 on electronic ones.
- R7: In the cycle after the last optical beat, a control packet with cp_out_type 2'b10 (breakdown) is sent to the same destination, and the gateway is idle in the next cycle.
- R8: With cfg_selective 1 and length below 256, beats start in the cycle after acceptance with dout_optical 0, and no control packet is sent. A length of 256 or more, or cfg_selective 0, takes the optical route.
- R9: A matching negative acknowledgement (cp_in_type 2'b11) in the waiting phase makes the setup packet reappear exactly cfg_backoff+2 cycles after the cycle in which it was presented, with no control packet in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_selective | input | 1 | Divert short messages to the electronic network |
| cfg_backoff | input | BO_W | Retry wait after a blocked path, in cycles |
| req_valid | input | 1 | Message descriptor present |
| req_ready | output | 1 | Gateway idle and able to take a descriptor |
| req_dst | input | ID_W | Destination node id |
| req_len | input | LEN_W | Message length in bytes |
| cp_out_valid | output | 1 | Outgoing control packet present |
| cp_out_type | output | 2 | 00 setup, 10 breakdown |
| cp_out_src | output | ID_W | Source id (NODE_ID) |
| cp_out_dst | output | ID_W | Destination id |
| cp_in_valid | input | 1 | Incoming control packet present |
| cp_in_type | input | 2 | 01 ack, 11 nack |
| cp_in_src | input | ID_W | Sender of the incoming packet |
| cp_in_dst | input | ID_W | Addressee of the incoming packet |
| beat_idx | output | LEN_W | Index of the beat being sent |
| beat_data | input | DATA_W | Payload word for beat_idx, from the node |
| dout_valid | output | 1 | Payload beat present |
| dout_data | output | DATA_W | Payload beat |
| dout_last | output | 1 | Final beat of the message |
| dout_optical | output | 1 | 1 on the optical path, 0 on the electronic network |

## Verification
A setup packet is due one cycle after acceptance, and so is the first electronic beat. The first optical beat is due one cycle after the matching acknowledgement. The breakdown packet follows one cycle after the last beat, and the gateway is idle one cycle after that. A retried setup is due cfg_backoff+2 cycles after the negative acknowledgement. The bench drives and samples on the falling edge and steps through these cycles one at a time. At every step it compares packet, beat index, last flag and ready against values worked out from the length, the mode and the backoff. Rejected acknowledgements are followed by a cycle where the bench confirms that no beat started.

// File: rtl/gw_pkg.sv
package gw_pkg;
  typedef enum logic [1:0] {
    PKT_SETUP = 2'b00,
    PKT_ACK   = 2'b01,
    PKT_BREAK = 2'b10,
    PKT_NACK  = 2'b11
  } pkt_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_WAIT    = 3'd2,
    ST_XMIT    = 3'd3,
    ST_TEAR    = 3'd4,
    ST_ELEC    = 3'd5,
    ST_BACKOFF = 3'd6
  } gw_state_t;
endpackage

// File: rtl/gw_beat_plan.sv
module gw_beat_plan #(
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 8,
  parameter int THRESH     = 256
) (
  input  logic             sel,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] beats,
  output logic             use_elec
);
  localparam int SUM_W = LEN_W + 1;
  localparam logic [SUM_W-1:0] ROUND = SUM_W'(BEAT_BYTES - 1);
  localparam bit POW2 = ((BEAT_BYTES & (BEAT_BYTES - 1)) == 0);
  localparam int SHIFT = $clog2(BEAT_BYTES);

  logic [SUM_W-1:0] padded;
  logic [SUM_W-1:0] quot;

  assign padded = {1'b0, len} + ROUND;

  generate
    if (POW2) begin : g_shift
      assign quot = padded >> SHIFT;
    end else begin : g_div
      assign quot = padded / SUM_W'(BEAT_BYTES);
    end
  endgenerate

  always_comb begin
    if (len == '0) beats = LEN_W'(1);
    else           beats = quot[LEN_W-1:0];
  end

  assign use_elec = sel && ({1'b0, len} < SUM_W'(THRESH));
endmodule

// File: rtl/gw_beat_ctr.sv
module gw_beat_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] total_in,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             at_last
);
  logic [CNT_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             total_en, count_en;

  assign total_en = load;
  assign count_en = load || step;

  always_comb begin
    total_d = total_in;
    if (load) count_d = '0;
    else      count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= CNT_W'(1);
      count_q <= '0;
    end else begin
      if (total_en) total_q <= total_d;
      if (count_en) count_q <= count_d;
    end
  end

  assign count   = count_q;
  assign at_last = (count_q == total_q - CNT_W'(1));
endmodule

// File: rtl/gw_backoff.sv
module gw_backoff #(
  parameter int BO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BO_W-1:0] wait_cycles,
  input  logic            run,
  output logic            expired
);
  logic [BO_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign cnt_en = load || (run && (cnt_q != '0));

  always_comb begin
    if (load) cnt_d = wait_cycles;
    else      cnt_d = cnt_q - BO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/gw_fsm.sv
module gw_fsm
  import gw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  logic      use_elec,
  input  logic      ack_ok,
  input  logic      nack_ok,
  input  logic      at_last,
  input  logic      bo_expired,
  output gw_state_t state
);
  gw_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = use_elec ? ST_ELEC : ST_SETUP;
      ST_SETUP:   state_d = ST_WAIT;
      ST_WAIT: begin
        if (ack_ok)       state_d = ST_XMIT;
        else if (nack_ok) state_d = ST_BACKOFF;
      end
      ST_BACKOFF: if (bo_expired) state_d = ST_SETUP;
      ST_XMIT:    if (at_last) state_d = ST_TEAR;
      ST_TEAR:    state_d = ST_IDLE;
      ST_ELEC:    if (at_last) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/path_gateway.sv
module path_gateway
  import gw_pkg::*;
#(
  parameter int          ID_W       = 4,
  parameter int          LEN_W      = 16,
  parameter int          DATA_W     = 64,
  parameter int          BEAT_BYTES = 8,
  parameter int          THRESH     = 256,
  parameter int          BO_W       = 8,
  parameter logic [3:0]  NODE_ID    = 4'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_selective,
  input  logic [BO_W-1:0]   cfg_backoff,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_dst,
  input  logic [LEN_W-1:0]  req_len,
  output logic              cp_out_valid,
  output logic [1:0]        cp_out_type,
  output logic [ID_W-1:0]   cp_out_src,
  output logic [ID_W-1:0]   cp_out_dst,
  input  logic              cp_in_valid,
  input  logic [1:0]        cp_in_type,
  input  logic [ID_W-1:0]   cp_in_src,
  input  logic [ID_W-1:0]   cp_in_dst,
  output logic [LEN_W-1:0]  beat_idx,
  input  logic [DATA_W-1:0] beat_data,
  output logic              dout_valid,
  output logic [DATA_W-1:0] dout_data,
  output logic              dout_last,
  output logic              dout_optical
);
  localparam logic [ID_W-1:0] SELF = ID_W'(NODE_ID);

  gw_state_t        state;
  logic             accept, use_elec, at_last, bo_expired;
  logic             ack_ok, nack_ok, from_peer;
  logic [LEN_W-1:0] beats;
  logic [ID_W-1:0]  dst_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_q <= '0;
    else if (accept) dst_q <= req_dst;
  end

  assign from_peer = cp_in_valid && (state == ST_WAIT) &&
                     (cp_in_src == dst_q) && (cp_in_dst == SELF);
  assign ack_ok    = from_peer && (cp_in_type == PKT_ACK);
  assign nack_ok   = from_peer && (cp_in_type == PKT_NACK);

  gw_beat_plan #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .THRESH(THRESH)) u_plan (
    .sel      (cfg_selective),
    .len      (req_len),
    .beats    (beats),
    .use_elec (use_elec)
  );

  gw_beat_ctr #(.CNT_W(LEN_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .total_in (beats),
    .step     (dout_valid),
    .count    (beat_idx),
    .at_last  (at_last)
  );

  gw_backoff #(.BO_W(BO_W)) u_bo (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (nack_ok),
    .wait_cycles (cfg_backoff),
    .run         (state == ST_BACKOFF),
    .expired     (bo_expired)
  );

  gw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .use_elec   (use_elec),
    .ack_ok     (ack_ok),
    .nack_ok    (nack_ok),
    .at_last    (at_last),
    .bo_expired (bo_expired),
    .state      (state)
  );

  assign cp_out_valid = (state == ST_SETUP) || (state == ST_TEAR);
  assign cp_out_type  = (state == ST_TEAR) ? PKT_BREAK : PKT_SETUP;
  assign cp_out_src   = SELF;
  assign cp_out_dst   = dst_q;

  assign dout_valid   = (state == ST_XMIT) || (state == ST_ELEC);
  assign dout_optical = (state == ST_XMIT);
  assign dout_last    = dout_valid && at_last;
  assign dout_data    = beat_data;
endmodule

// File: rtl/path_gateway_chk.sv
module path_gateway_chk #(
  parameter int         ID_W    = 4,
  parameter logic [3:0] NODE_ID = 4'd6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [ID_W-1:0] req_dst,
  input logic            cp_out_valid,
  input logic [1:0]      cp_out_type,
  input logic            cp_in_valid,
  input logic [1:0]      cp_in_type,
  input logic [ID_W-1:0] cp_in_src,
  input logic [ID_W-1:0] cp_in_dst,
  input logic            dout_valid,
  input logic            dout_last,
  input logic            dout_optical
);
  logic [ID_W-1:0] peer_q;
  logic            good_ack, good_nack, took;

  assign took = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    peer_q <= '0;
    else if (took) peer_q <= req_dst;
  end

  assign good_ack  = cp_in_valid && cp_in_type == 2'b01 &&
                     cp_in_src == peer_q && cp_in_dst == ID_W'(NODE_ID);
  assign good_nack = cp_in_valid && cp_in_type == 2'b11 &&
                     cp_in_src == peer_q && cp_in_dst == ID_W'(NODE_ID);

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid || cp_out_valid) |-> !req_ready);

  a_r3_setup_or_beat_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> ((cp_out_valid && cp_out_type == 2'b00) || (dout_valid && !dout_optical)));

  a_r4_data_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && dout_optical && !$past(dout_valid)) |-> $past(good_ack));

  a_r6_beats_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_last) |=> (dout_valid && $stable(dout_optical)));

  a_r7_teardown_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && dout_optical && dout_last) |=> (cp_out_valid && cp_out_type == 2'b10));

  a_r8_elec_no_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_optical) |-> !cp_out_valid);

  a_r9_nack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (good_nack && !dout_valid && !cp_out_valid) |=> (!cp_out_valid && !dout_valid));
endmodule

bind path_gateway path_gateway_chk #(.ID_W(ID_W), .NODE_ID(NODE_ID)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_dst      (req_dst),
  .cp_out_valid (cp_out_valid),
  .cp_out_type  (cp_out_type),
  .cp_in_valid  (cp_in_valid),
  .cp_in_type   (cp_in_type),
  .cp_in_src    (cp_in_src),
  .cp_in_dst    (cp_in_dst),
  .dout_valid   (dout_valid),
  .dout_last    (dout_last),
  .dout_optical (dout_optical)
);

// File: tb/path_gateway_bench.sv
module path_gateway_bench;
  localparam int ID_W = 4;
  localparam int LEN_W = 16;
  localparam int DATA_W = 64;
  localparam int BO_W = 8;
  localparam logic [3:0] SELF = 4'd6;
  localparam int NV = 8;

  localparam int V_SEL  [NV] = '{1, 1, 1, 0, 0, 1, 0, 0};
  localparam int V_LEN  [NV] = '{100, 255, 256, 100, 8, 0, 0, 1000};
  localparam int V_DST  [NV] = '{3, 4, 5, 5, 1, 2, 2, 9};
  localparam int V_NACK [NV] = '{0, 0, 0, 0, 1, 0, 0, 1};
  localparam int V_BO   [NV] = '{0, 0, 0, 0, 3, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_selective;
  logic [BO_W-1:0] cfg_backoff;
  logic req_valid, req_ready;
  logic [ID_W-1:0] req_dst;
  logic [LEN_W-1:0] req_len;
  logic cp_out_valid;
  logic [1:0] cp_out_type;
  logic [ID_W-1:0] cp_out_src, cp_out_dst;
  logic cp_in_valid;
  logic [1:0] cp_in_type;
  logic [ID_W-1:0] cp_in_src, cp_in_dst;
  logic [LEN_W-1:0] beat_idx;
  logic [DATA_W-1:0] beat_data;
  logic dout_valid, dout_last, dout_optical;
  logic [DATA_W-1:0] dout_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign beat_data = {16'hA5C3, 16'h0F1E, 16'h0000, beat_idx};

  path_gateway u_path_gateway (
    .clk(clk), .rst_n(rst_n), .cfg_selective(cfg_selective), .cfg_backoff(cfg_backoff),
    .req_valid(req_valid), .req_ready(req_ready), .req_dst(req_dst), .req_len(req_len),
    .cp_out_valid(cp_out_valid), .cp_out_type(cp_out_type), .cp_out_src(cp_out_src),
    .cp_out_dst(cp_out_dst), .cp_in_valid(cp_in_valid), .cp_in_type(cp_in_type),
    .cp_in_src(cp_in_src), .cp_in_dst(cp_in_dst), .beat_idx(beat_idx),
    .beat_data(beat_data), .dout_valid(dout_valid), .dout_data(dout_data),
    .dout_last(dout_last), .dout_optical(dout_optical)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_cp(input logic v, input logic [1:0] t, input logic [3:0] s,
                          input logic [3:0] d);
    cp_in_valid = v; cp_in_type = t; cp_in_src = s; cp_in_dst = d;
  endtask

  task automatic expect_beats(input int nb, input bit opt, input string tag);
    for (int k = 0; k < nb; k++) begin
      check(dout_valid == 1'b1, {tag, " beat valid"}, 64'(dout_valid), 64'd1);
      check(dout_optical == opt, {tag, " path flag"}, 64'(dout_optical), 64'(opt));
      check(beat_idx == LEN_W'(k), "R6 beat index", 64'(beat_idx), 64'(k));
      check(dout_last == (k == nb - 1), "R6 last flag", 64'(dout_last), 64'(k == nb - 1));
      check(dout_data == {16'hA5C3, 16'h0F1E, 16'h0000, LEN_W'(k)}, "R6 data",
            dout_data, {16'hA5C3, 16'h0F1E, 16'h0000, 16'(k)});
      check(req_ready == 1'b0, "R2 ready low while sending", 64'(req_ready), 64'd0);
      if (!opt) check(cp_out_valid == 1'b0, "R8 no control packet", 64'(cp_out_valid), 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic run_msg(input bit sel, input int len, input int dst, input bit nack,
                         input int bo);
    int nb;
    bit elec;
    nb = (len == 0) ? 1 : (len + 7) / 8;
    elec = sel && (len < 256);
    check(req_ready == 1'b1, "R2 ready before request", 64'(req_ready), 64'd1);
    cfg_selective = sel; cfg_backoff = BO_W'(bo);
    req_valid = 1'b1; req_len = LEN_W'(len); req_dst = ID_W'(dst);
    @(negedge clk);
    req_valid = 1'b0;
    if (elec) begin
      expect_beats(nb, 1'b0, "R8");
      check(req_ready == 1'b1, "R2 ready after electronic send", 64'(req_ready), 64'd1);
      check(dout_valid == 1'b0, "R8 quiet after last", 64'(dout_valid), 64'd0);
    end else begin
      check(cp_out_valid && cp_out_type == 2'b00, "R3 setup packet",
            64'({cp_out_valid, cp_out_type}), 64'({1'b1, 2'b00}));
      check(cp_out_dst == ID_W'(dst) && cp_out_src == SELF, "R3 setup ids",
            64'({cp_out_src, cp_out_dst}), 64'({SELF, 4'(dst)}));
      @(negedge clk);
      check(dout_valid == 1'b0 && cp_out_valid == 1'b0, "R4 waiting for ack",
            64'({dout_valid, cp_out_valid}), 64'd0);
      drive_cp(1'b1, 2'b01, 4'(dst) ^ 4'd1, SELF);
      @(negedge clk);
      check(dout_valid == 1'b0, "R5 ack from wrong source ignored", 64'(dout_valid), 64'd0);
      drive_cp(1'b1, 2'b01, 4'(dst), SELF ^ 4'd1);
      @(negedge clk);
      drive_cp(1'b0, 2'b00, 4'd0, 4'd0);
      check(dout_valid == 1'b0, "R5 ack to wrong node ignored", 64'(dout_valid), 64'd0);
      if (nack) begin
        drive_cp(1'b1, 2'b11, 4'(dst), SELF);
        @(negedge clk);
        drive_cp(1'b0, 2'b00, 4'd0, 4'd0);
        for (int i = 0; i <= bo; i++) begin
          check(cp_out_valid == 1'b0 && dout_valid == 1'b0, "R9 quiet during backoff",
                64'({cp_out_valid, dout_valid}), 64'd0);
          @(negedge clk);
        end
        check(cp_out_valid && cp_out_type == 2'b00 && cp_out_dst == ID_W'(dst),
              "R9 setup retried", 64'({cp_out_valid, cp_out_type, cp_out_dst}),
              64'({1'b1, 2'b00, 4'(dst)}));
        @(negedge clk);
      end
      drive_cp(1'b1, 2'b01, 4'(dst), SELF);
      @(negedge clk);
      drive_cp(1'b0, 2'b00, 4'd0, 4'd0);
      expect_beats(nb, 1'b1, "R4");
      check(cp_out_valid && cp_out_type == 2'b10 && cp_out_dst == ID_W'(dst),
            "R7 breakdown packet", 64'({cp_out_valid, cp_out_type, cp_out_dst}),
            64'({1'b1, 2'b10, 4'(dst)}));
      check(req_ready == 1'b0, "R2 ready low during breakdown", 64'(req_ready), 64'd0);
      @(negedge clk);
      check(req_ready == 1'b1 && cp_out_valid == 1'b0, "R7 idle after breakdown",
            64'({req_ready, cp_out_valid}), 64'({1'b1, 1'b0}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_selective = 1'b0; cfg_backoff = '0;
    req_valid = 1'b0; req_dst = '0; req_len = '0;
    drive_cp(1'b0, 2'b00, 4'd0, 4'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && cp_out_valid == 1'b0 && dout_valid == 1'b0,
          "R1 reset state", 64'({req_ready, cp_out_valid, dout_valid}), 64'b100);

    // R5: an acknowledgement while idle has no effect
    drive_cp(1'b1, 2'b01, 4'd0, SELF);
    @(negedge clk);
    drive_cp(1'b0, 2'b00, 4'd0, 4'd0);
    check(dout_valid == 1'b0 && req_ready == 1'b1, "R5 ack while idle ignored",
          64'({dout_valid, req_ready}), 64'b01);

    for (int v = 0; v < NV; v++)
      run_msg(V_SEL[v] != 0, V_LEN[v], V_DST[v], V_NACK[v] != 0, V_BO[v]);

    // R1: reset while waiting for an acknowledgement
    cfg_selective = 1'b0; req_valid = 1'b1; req_len = 16'd16; req_dst = 4'd4;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0, "R2 blocked while path pending", 64'(req_ready), 64'd0);
    rst_n = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1 && cp_out_valid == 1'b0 && dout_valid == 1'b0,
          "R1 reset mid message", 64'({req_ready, cp_out_valid, dout_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    run_msg(1'b0, 24, 7, 1'b1, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule